// File: doc/BRIEF.md
# Harvester power-path sequencing controller

This block is the supervisory state machine of a multi-stage energy-harvesting power path. It receives three comparator results: core supply above its target, storage voltage above its buck-enable threshold, and load voltage at its target. The comparators are not synchronous to the controller clock, so each result passes through a synchronizer first. From the synchronized flags the controller decides which phase the power path is in. It then drives five enables: charge pulses into the core supply from the start path, the storage boost stage, the clock gate of the buck stage, the switch that ties the core rail to the load rail, and the switch that shuts the start path off.

The controller begins work once an external one-time kick has raised the core supply far enough for the logic to run. Power-on reset marks that moment, and no further external input is needed. The start path pumps the core rail while it is below target. When the core rail reaches target, energy goes to the storage boost instead. When storage passes its threshold, the buck stage is ungated. When the load reaches its target, the core and load rails are merged and the start path is shut off. From then on the buck output feeds the core rail and the boost runs at its fixed rate. If the core rail drops below target at any later point, the controller falls back to pumping and separates the rails.

Top module: `harvest_seq`

## Requirements
- R1: While rst_n is low, phase is 0, core_pump, boost_en, buck_clk_en and start_off are low, and rail_sep_n is high.
- R2: On the first rising edge after rst_n goes high, phase moves from idle (0) to start-pump (1).
- R3: Each comparator flag passes through a two-stage synchronizer. A change on an input that is held steady first affects phase at the third rising edge after the change.
- R4: core_pump is high only in start-pump, and only while the synchronized core flag is low. Phase leaves start-pump for store-charge (2) once the synchronized core flag is high.
- R5: boost_en is high in store-charge, buck-ramp (3) and merged (4), and low in idle and start-pump.
- R6: In store-charge, a high synchronized storage flag moves phase to buck-ramp. In buck-ramp, a low synchronized storage flag moves phase back to store-charge. buck_clk_en is high only in buck-ramp or merged, and only while the synchronized storage flag is high.
- R7: In buck-ramp, a high synchronized load flag moves phase to merged (when core and storage flags are also high). In merged, rail_sep_n is low and start_off is high. In every other phase, rail_sep_n is high and start_off is low.
- R8: In store-charge, buck-ramp or merged, a low synchronized core flag moves phase to start-pump, which releases the rail merge. Losing the core flag takes priority over every other transition.
- R9: phase encodes idle=0, start-pump=1, store-charge=2, buck-ramp=3, merged=4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_hi_a | input | 1 | Comparator: core supply above target (asynchronous) |
| sto_hi_a | input | 1 | Comparator: storage above buck-enable threshold (asynchronous) |
| load_hi_a | input | 1 | Comparator: load supply at target (asynchronous) |
| core_pump | output | 1 | Start-path charge pulse request into core supply |
| boost_en | output | 1 | Storage boost stage enable |
| buck_clk_en | output | 1 | Clock gate for the buck stage comparator |
| rail_sep_n | output | 1 | High keeps core and load rails apart; low merges them |
| start_off | output | 1 | Disables the start-path inductor and rectifier route |
| phase | output | 3 | Current phase, for test observation |

## Verification
The bench builds the block with its default two-stage synchronizer, so any flag change takes three edges to reach phase. The bench checks the edge where phase must still be unchanged and the edge where it must have moved. The bench brings the controller into each of the four reachable working phases. In each one it applies every one of the eight combinations of the three flags, and then compares phase and all five enables against the transition table worked out from the requirements. This reaches the core-flag fallback from each phase, the storage-drop fallback from buck-ramp, and the buck gate following the storage flag while merged.

// File: rtl/harvest_seq.sv
module harvest_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_hi_a,
  input  logic       sto_hi_a,
  input  logic       load_hi_a,
  output logic       core_pump,
  output logic       boost_en,
  output logic       buck_clk_en,
  output logic       rail_sep_n,
  output logic       start_off,
  output logic [2:0] phase
);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PUMP  = 3'd1,
    PH_STORE = 3'd2,
    PH_BUCK  = 3'd3,
    PH_MERGE = 3'd4
  } phase_t;

  logic [2:0] sync_q [SYNC_STAGES];
  logic       core_ok, sto_ok, load_ok;
  phase_t     cur, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {load_hi_a, sto_hi_a, core_hi_a};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign core_ok = sync_q[SYNC_STAGES-1][0];
  assign sto_ok  = sync_q[SYNC_STAGES-1][1];
  assign load_ok = sync_q[SYNC_STAGES-1][2];

  always_comb begin
    nxt = cur;
    unique case (cur)
      PH_IDLE:  nxt = PH_PUMP;
      PH_PUMP:  if (core_ok) nxt = PH_STORE;
      PH_STORE: if (!core_ok) nxt = PH_PUMP;
                else if (sto_ok) nxt = PH_BUCK;
      PH_BUCK:  if (!core_ok) nxt = PH_PUMP;
                else if (!sto_ok) nxt = PH_STORE;
                else if (load_ok) nxt = PH_MERGE;
      PH_MERGE: if (!core_ok) nxt = PH_PUMP;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= PH_IDLE;
    else        cur <= nxt;
  end

  assign core_pump   = (cur == PH_PUMP) && !core_ok;
  assign boost_en    = (cur == PH_STORE) || (cur == PH_BUCK) || (cur == PH_MERGE);
  assign buck_clk_en = ((cur == PH_BUCK) || (cur == PH_MERGE)) && sto_ok;
  assign rail_sep_n  = (cur != PH_MERGE);
  assign start_off   = (cur == PH_MERGE);
  assign phase       = cur;

endmodule

// File: rtl/harvest_seq_chk.sv
module harvest_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_pump,
  input logic       boost_en,
  input logic       buck_clk_en,
  input logic       rail_sep_n,
  input logic       start_off,
  input logic [2:0] phase
);

  assert_phase_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);

  assert_pump_boost_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_pump && boost_en));

  assert_buck_needs_boost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buck_clk_en |-> boost_en);

  assert_merge_kills_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_sep_n |-> (start_off && !core_pump));

  assert_pump_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 3'd1 && phase != 3'd1) |-> phase == 3'd2);

  assert_merge_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 3'd4 && phase != 3'd4) |-> (phase == 3'd1 && rail_sep_n));

  assert_merge_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_sep_n) |-> $past(phase) == 3'd3);

endmodule

bind harvest_seq harvest_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_pump(core_pump), .boost_en(boost_en),
  .buck_clk_en(buck_clk_en), .rail_sep_n(rail_sep_n), .start_off(start_off),
  .phase(phase)
);

// File: tb/tb_harvest_seq.sv
module tb_harvest_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_hi_a = 1'b0, sto_hi_a = 1'b0, load_hi_a = 1'b0;
  logic core_pump, boost_en, buck_clk_en, rail_sep_n, start_off;
  logic [2:0] phase;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  harvest_seq dut (
    .clk(clk), .rst_n(rst_n), .core_hi_a(core_hi_a), .sto_hi_a(sto_hi_a),
    .load_hi_a(load_hi_a), .core_pump(core_pump), .boost_en(boost_en),
    .buck_clk_en(buck_clk_en), .rail_sep_n(rail_sep_n), .start_off(start_off),
    .phase(phase)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [2:0] f);
    core_hi_a = f[0]; sto_hi_a = f[1]; load_hi_a = f[2];
  endtask

  function automatic int next_ph(input int s, input logic [2:0] f);
    case (s)
      1: return f[0] ? 2 : 1;
      2: return !f[0] ? 1 : (f[1] ? 3 : 2);
      3: return !f[0] ? 1 : (!f[1] ? 2 : (f[2] ? 4 : 3));
      4: return !f[0] ? 1 : 4;
      default: return 0;
    endcase
  endfunction

  task automatic go_to(input int s);
    rst_n = 1'b0; set_flags(3'b000); step(2);
    rst_n = 1'b1; step(4);
    if (s >= 2) begin set_flags(3'b001); step(4); end
    if (s >= 3) begin set_flags(3'b011); step(4); end
    if (s >= 4) begin set_flags(3'b111); step(4); end
  endtask

  task automatic check_outs(input int ns, input logic [2:0] f);
    chk("R8/R9 phase", phase, ns);
    chk("R4 core_pump", core_pump, (ns == 1 && !f[0]) ? 1 : 0);
    chk("R5 boost_en", boost_en, (ns >= 2) ? 1 : 0);
    chk("R6 buck_clk_en", buck_clk_en, ((ns == 3 || ns == 4) && f[1]) ? 1 : 0);
    chk("R7 rail_sep_n", rail_sep_n, (ns == 4) ? 0 : 1);
    chk("R7 start_off", start_off, (ns == 4) ? 1 : 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    set_flags(3'b000);
    step(3);
    chk("R1 phase", phase, 0);
    chk("R1 core_pump", core_pump, 0);
    chk("R1 boost_en", boost_en, 0);
    chk("R1 buck_clk_en", buck_clk_en, 0);
    chk("R1 rail_sep_n", rail_sep_n, 1);
    chk("R1 start_off", start_off, 0);
    rst_n = 1'b1;
    step(1);
    chk("R2 leave idle", phase, 1);
    chk("R4 pump while core low", core_pump, 1);

    set_flags(3'b001);
    step(2);
    chk("R3 no change after two edges", phase, 1);
    step(1);
    chk("R3 change on third edge", phase, 2);

    for (int s = 1; s <= 4; s++) begin
      for (int f = 0; f < 8; f++) begin
        go_to(s);
        chk("R9 reached phase", phase, s);
        set_flags(f[2:0]);
        step(2);
        chk("R3 held phase", phase, s);
        step(1);
        check_outs(next_ph(s, f[2:0]), f[2:0]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule